// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Unit

This block holds the interrupt bookkeeping of an SD host controller: a sticky status register, a status-enable mask and a signal-enable mask. Single-cycle event pulses from the command path, the data path and the DMA engine set their status bits. A pulse is recorded only when its status-enable bit is set. Software reads the status over a 32-bit register port and clears bits by writing ones to them.

A single interrupt line is driven from the status bits whose signal-enable bits are also set. Masking an event from the line therefore does not stop software from seeing that event by polling. A command-timeout event is held in the upper half of the status word. An error-summary bit in the lower half reports that some error is pending, so a driver can test one bit and learn whether to look further.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset the status, status-enable and signal-enable registers read 0 and the interrupt output is 0.
- R2: An event pulse sets its status bit at the next clock edge only if the matching status-enable bit is set. The bit positions are command complete 0, transfer complete 1, DMA boundary 3, buffer write ready 4, buffer read ready 5 and command timeout 16. An event whose enable bit is clear changes nothing.
- R3: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: Status bit 15 reads 1 while any status bit in 31:16 is set. A write to bit 15 has no effect on it. Bit 15 drops once the pending error bits have been cleared.
- R5: If an event pulse and a clear write for the same bit arrive in the same cycle, the bit ends up set.
- R6: The interrupt output is registered. In each cycle it equals the OR, over all bits, of the status read value AND the signal-enable register, as they stood in the previous cycle.
- R7: Address 1 is the status-enable register and holds only bits 0, 1, 3, 4, 5 and 16 (mask 0x0001003B). Address 2 is the signal-enable register and holds only bits 0, 1, 3, 4, 5, 15 and 16 (mask 0x0001803B). All other bits read 0, and address 3 reads 0.
- R8: A status bit keeps its value in any cycle that has neither a recorded event nor a clear for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 status, 1 status-enable, 2 signal-enable |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ev_cmd_done | input | 1 | Command complete pulse |
| ev_xfer_done | input | 1 | Transfer complete pulse |
| ev_dma_bndry | input | 1 | DMA boundary pulse |
| ev_wbuf_rdy | input | 1 | Buffer write ready pulse |
| ev_rbuf_rdy | input | 1 | Buffer read ready pulse |
| ev_cmd_tmo | input | 1 | Command timeout pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that event pulses and register writes are sampled only on the clock edge and that reset is applied before the first check. They also assume that a clear write names only the status address. The properties about bit 15 further assume that it can fall only in a cycle in which the status register was written. The bench drives every input at the falling edge from a fixed-seed random stream. It writes only to addresses 0 to 3 and adds directed cycles that hit a clear and an event on the same bit, and a write to the summary bit.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
   localparam int unsigned REG_W = 32;
   localparam int unsigned ADR_W = 2;

   localparam int unsigned B_CMD  = 0;
   localparam int unsigned B_XFER = 1;
   localparam int unsigned B_DMA  = 3;
   localparam int unsigned B_WBUF = 4;
   localparam int unsigned B_RBUF = 5;
   localparam int unsigned B_ESUM = 15;
   localparam int unsigned B_TMO  = 16;
   localparam int unsigned N_EVT  = 6;

   localparam logic [REG_W-1:0] STS_MASK = 32'h0001_003B;
   localparam logic [REG_W-1:0] SIG_MASK = 32'h0001_803B;

   typedef enum logic [ADR_W-1:0] {
      A_STS = 2'd0,
      A_STE = 2'd1,
      A_SGE = 2'd2,
      A_RSV = 2'd3
   } reg_sel_t;
endpackage

// File: rtl/sdh_irq_evmap.sv
module sdh_irq_evmap
   import sdh_irq_pkg::*;
#(
   parameter int unsigned W = REG_W
) (
   input  logic [N_EVT-1:0] ev_i,
   output logic [W-1:0]     vec_o
);
   localparam int unsigned POS [N_EVT] = '{B_CMD, B_XFER, B_DMA, B_WBUF, B_RBUF, B_TMO};

   generate
      if (W <= B_TMO) begin : g_bad
         $error("sdh_irq_evmap: width too small for the timeout bit");
      end
   endgenerate

   always_comb begin
      vec_o = '0;
      for (int k = 0; k < N_EVT; k++) begin
         vec_o[POS[k]] = ev_i[k];
      end
   end
endmodule

// File: rtl/sdh_irq_en.sv
module sdh_irq_en #(
   parameter int unsigned   W    = 32,
   parameter logic [W-1:0]  MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (MASK[i]) begin : g_ff
            logic b_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    b_q <= 1'b0;
               else if (we_i) b_q <= wdata_i[i];
            end
            assign q_o[i] = b_q;
         end else begin : g_zero
            assign q_o[i] = 1'b0;
         end
      end
   endgenerate

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o)); // R7
endmodule

// File: rtl/sdh_irq_sts.sv
module sdh_irq_sts #(
   parameter int unsigned   W    = 32,
   parameter logic [W-1:0]  MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] sts_o
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (MASK[i]) begin : g_ff
            logic b_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         b_q <= 1'b0;
               else if (set_i[i])  b_q <= 1'b1;
               else if (clr_i[i])  b_q <= 1'b0;
            end
            assign sts_o[i] = b_q;
         end else begin : g_zero
            assign sts_o[i] = 1'b0;
         end
      end
   endgenerate

   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((sts_o & $past(clr_i & ~set_i)) == '0)); // R3
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & MASK)) |=> ((sts_o & $past(set_i & MASK)) == $past(set_i & MASK))); // R5
   AST_NO_SPURIOUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0) |=> ((sts_o & ~$past(sts_o)) == '0)); // R2
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i == '0) && (clr_i == '0)) |=> $stable(sts_o)); // R8
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
   import sdh_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = REG_W,
   parameter int unsigned ADDR_W  = ADR_W,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_cmd_done,
   input  logic              ev_xfer_done,
   input  logic              ev_dma_bndry,
   input  logic              ev_wbuf_rdy,
   input  logic              ev_rbuf_rdy,
   input  logic              ev_cmd_tmo,
   output logic              irq_o
);
   localparam int unsigned HALF = DATA_W / 2;

   generate
      if (DATA_W != REG_W) begin : g_bad_w
         $error("sdh_irq_status: DATA_W must be 32");
      end
      if (ADDR_W != ADR_W) begin : g_bad_a
         $error("sdh_irq_status: ADDR_W must be 2");
      end
   endgenerate

   logic [DATA_W-1:0] ev_vec, set_vec, clr_vec;
   logic [DATA_W-1:0] sts_raw, sts_view, ste_q, sge_q;
   logic              wr_sts, wr_ste, wr_sge, err_sum, irq_next;

   assign wr_sts = reg_we && (reg_addr == A_STS);
   assign wr_ste = reg_we && (reg_addr == A_STE);
   assign wr_sge = reg_we && (reg_addr == A_SGE);

   sdh_irq_evmap #(.W(DATA_W)) u_map (
      .ev_i  ({ev_cmd_tmo, ev_rbuf_rdy, ev_wbuf_rdy, ev_dma_bndry, ev_xfer_done, ev_cmd_done}),
      .vec_o (ev_vec)
   );

   sdh_irq_en #(.W(DATA_W), .MASK(STS_MASK)) u_ste (
      .clk(clk), .rst_n(rst_n), .we_i(wr_ste), .wdata_i(reg_wdata), .q_o(ste_q)
   );

   sdh_irq_en #(.W(DATA_W), .MASK(SIG_MASK)) u_sge (
      .clk(clk), .rst_n(rst_n), .we_i(wr_sge), .wdata_i(reg_wdata), .q_o(sge_q)
   );

   assign set_vec = ev_vec & ste_q;
   assign clr_vec = wr_sts ? reg_wdata : '0;

   sdh_irq_sts #(.W(DATA_W), .MASK(STS_MASK)) u_sts (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .sts_o(sts_raw)
   );

   assign err_sum = |sts_raw[DATA_W-1:HALF];

   always_comb begin
      sts_view         = sts_raw;
      sts_view[B_ESUM] = err_sum;
   end

   always_comb begin
      unique case (reg_sel_t'(reg_addr))
         A_STS:   reg_rdata = sts_view;
         A_STE:   reg_rdata = ste_q;
         A_SGE:   reg_rdata = sge_q;
         default: reg_rdata = '0;
      endcase
   end

   assign irq_next = |(sts_view & sge_q);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_next;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_next;
      end
   endgenerate

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sge_q == '0) |=> !irq_o); // R6
   AST_SUM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_view[B_ESUM]) |-> $past(wr_sts)); // R4
   AST_SUM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_view[B_ESUM]) |-> $past(ev_cmd_tmo && ste_q[B_TMO])); // R4
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_RSV) |-> (reg_rdata == '0)); // R7
endmodule

// File: tb/sim_sdh_irq_status.sv
module sim_sdh_irq_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  ev = '0;
   logic        irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] sts_m = '0, ste_m = '0, sge_m = '0;
   logic        irq_m = 1'b0;

   always #2 clk = ~clk;

   sdh_irq_status u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_cmd_done(ev[0]), .ev_xfer_done(ev[1]), .ev_dma_bndry(ev[2]),
      .ev_wbuf_rdy(ev[3]), .ev_rbuf_rdy(ev[4]), .ev_cmd_tmo(ev[5]),
      .irq_o(irq_o)
   );

   function automatic logic [31:0] view(input logic [31:0] s);
      logic [31:0] v = s;
      v[15] = |s[31:16];
      return v;
   endfunction

   function automatic logic [31:0] mread(input logic [1:0] a);
      case (a)
         2'd0:    return view(sts_m);
         2'd1:    return ste_m;
         2'd2:    return sge_m;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] evmap(input logic [5:0] e);
      logic [31:0] v = '0;
      v[0] = e[0]; v[1] = e[1]; v[3] = e[2]; v[4] = e[3]; v[5] = e[4]; v[16] = e[5];
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input string tag, input logic [1:0] a, input logic we,
                       input logic [31:0] wd, input logic [5:0] e);
      logic [31:0] clr;
      @(negedge clk);
      reg_addr = a; reg_we = we; reg_wdata = wd; ev = e;
      #1;
      chk(tag, reg_rdata, mread(a));
      chk("R6", {31'b0, irq_o}, {31'b0, irq_m});
      @(posedge clk);
      irq_m = |(view(sts_m) & sge_m);
      clr   = (we && a == 2'd0) ? wd : 32'h0;
      sts_m = ((sts_m & ~clr) | (evmap(e) & ste_m)) & 32'h0001_003B;
      if (we && a == 2'd1) ste_m = wd & 32'h0001_003B;
      if (we && a == 2'd2) sge_m = wd & 32'h0001_803B;
   endtask

   initial begin
      #40000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd4242);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset values on every address
      for (int a = 0; a < 4; a++) step("R1", a[1:0], 1'b0, 32'h0, 6'h0);
      // R2: event without enable is not recorded
      step("R2", 2'd0, 1'b0, 32'h0, 6'h3F);
      step("R2", 2'd0, 1'b0, 32'h0, 6'h0);
      // R7: enables keep only implemented bits
      step("R7", 2'd1, 1'b1, 32'hFFFF_FFFF, 6'h0);
      step("R7", 2'd1, 1'b0, 32'h0, 6'h0);
      step("R7", 2'd2, 1'b1, 32'hFFFF_FFFF, 6'h0);
      step("R7", 2'd2, 1'b0, 32'h0, 6'h0);
      step("R7", 2'd3, 1'b1, 32'hFFFF_FFFF, 6'h0);
      // R2: all events recorded, timeout drives the summary
      step("R2", 2'd0, 1'b0, 32'h0, 6'h3F);
      step("R4", 2'd0, 1'b0, 32'h0, 6'h0);
      // R4: writing bit 15 does not clear the summary
      step("R4", 2'd0, 1'b1, 32'h0000_8000, 6'h0);
      step("R4", 2'd0, 1'b0, 32'h0, 6'h0);
      // R3: write-one clears only selected bits
      step("R3", 2'd0, 1'b1, 32'h0000_0003, 6'h0);
      step("R3", 2'd0, 1'b0, 32'h0, 6'h0);
      // R5: clear and event on the same bit
      step("R5", 2'd0, 1'b1, 32'h0001_0038, 6'h20);
      step("R5", 2'd0, 1'b0, 32'h0, 6'h0);
      // R4: clearing timeout drops the summary
      step("R4", 2'd0, 1'b1, 32'h0001_0000, 6'h0);
      step("R4", 2'd0, 1'b0, 32'h0, 6'h0);
      // R8: nothing happens, bits hold
      step("R8", 2'd0, 1'b0, 32'h0, 6'h0);
      step("R8", 2'd0, 1'b1, 32'h0, 6'h0);
      // R6: no signal enable, no interrupt
      step("R6", 2'd2, 1'b1, 32'h0, 6'h3F);
      step("R6", 2'd0, 1'b0, 32'h0, 6'h0);
      step("R6", 2'd0, 1'b0, 32'h0, 6'h0);
      for (int i = 0; i < 3000; i++) begin
         logic [1:0]  a;
         logic        we;
         logic [31:0] wd;
         logic [5:0]  e;
         a  = 2'($urandom_range(0, 3));
         we = ($urandom_range(0, 3) == 0);
         wd = $urandom();
         e  = '0;
         for (int k = 0; k < 6; k++) e[k] = ($urandom_range(0, 5) == 0);
         step((a == 2'd0) ? "R8" : "R7", a, we, wd, e);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule